// File: doc/BRIEF.md
# Dual SPI Word Queue with Level-Match Flags

This block sits between a processor-side register file and a serial shift engine. It holds two independent word queues. The transmit queue collects words that software writes and hands them, oldest first, to the shift engine whenever the engine reports that it is idle. The receive queue collects words that the engine has shifted in and presents the oldest one to software until software pops it.

Each queue reports how many words it holds. It also compares that count against a programmable level and raises a sticky flag when the two are exactly equal. The flag reaches the interrupt output only while the queue's enable bit is set, and a write-one pulse clears it. The receive side has a sticky overflow flag with its own write-one clear.

A run bit per queue holds that queue's pointers at zero while it is low. A global mode bit chooses between queue mode and single-buffer mode. Single-buffer mode limits each side to one word and suppresses the level flags.

Top module: `spi_fifo_pair`

## Requirements
- R1: In queue mode each side holds up to DEPTH (16) words. The count output is 5 bits wide, reads 0 when the side is empty and 16 (binary 10000) when it is full. A transmit write while the side is full is dropped and leaves the count unchanged.
- R2: While `core_idle` is high, `tx_run` is high and the transmit count is non-zero, `core_load` is high for that cycle and `core_tx_data` carries the oldest stored word. That word is then removed. Words leave in the order they were written.
- R3: A word offered with `core_rx_valid` is stored at the receive tail. `rx_rdata` always shows the oldest stored word, and a pulse on `rx_rd` removes it.
- R4: A received word that arrives while the receive side is full is discarded, the stored words and the count are kept, and `rx_ovf` becomes 1 on the next cycle.
- R5: `rx_ovf` stays set until a cycle in which `rx_ovf_clr` is 1. While `rx_ovf_clr` is held at 0 the flag is unchanged.
- R6: In queue mode a side's flag (`tx_flag` / `rx_flag`) becomes 1 on the clock edge that follows a cycle in which its count equals its level input exactly. The flag stays set afterwards.
- R7: A 1 on a flag-clear input clears that flag at the next edge. If count and level still match in the cycle after the clear, the flag sets again one edge later. If they do not match, the flag stays clear.
- R8: `tx_irq` and `rx_irq` are high exactly when the corresponding flag is set and the corresponding enable input is 1.
- R9: While a side's run input is 0, its count reads 0 from the next edge onward and writes to that side are ignored. After the run input is raised again, the side restarts empty.
- R10: With `fifo_en` at 0, each side holds at most one word, so a second received word counts as an overflow. The level flags do not set in this mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fifo_en | input | 1 | 1 = queue mode, 0 = single-buffer mode |
| tx_run | input | 1 | 0 holds transmit pointers at zero |
| rx_run | input | 1 | 0 holds receive pointers at zero |
| tx_wr | input | 1 | Software write strobe for transmit side |
| tx_wdata | input | DW | Word written by software |
| core_idle | input | 1 | Shift engine ready for a new word |
| core_load | output | 1 | Word handed to the shift engine this cycle |
| core_tx_data | output | DW | Oldest transmit word |
| core_rx_valid | input | 1 | Shift engine delivers a received word |
| core_rx_data | input | DW | Received word |
| rx_rd | input | 1 | Software pop strobe for receive side |
| rx_rdata | output | DW | Oldest receive word |
| tx_count | output | CW | Transmit fill count |
| rx_count | output | CW | Receive fill count |
| tx_level | input | CW | Transmit match level |
| rx_level | input | CW | Receive match level |
| tx_ie | input | 1 | Transmit interrupt enable |
| rx_ie | input | 1 | Receive interrupt enable |
| tx_flag_clr | input | 1 | Write-one clear of transmit flag |
| rx_flag_clr | input | 1 | Write-one clear of receive flag |
| rx_ovf_clr | input | 1 | Write-one clear of overflow flag |
| tx_flag | output | 1 | Transmit level-match flag |
| rx_flag | output | 1 | Receive level-match flag |
| rx_ovf | output | 1 | Receive overflow flag |
| tx_irq | output | 1 | Transmit interrupt request |
| rx_irq | output | 1 | Receive interrupt request |

## Verification
The bench uses the default parameters, DW of 16 and DEPTH of 16. This makes the count field five bits wide, so the full value 10000 and a level of 16 can be tested directly. Sixteen pushes are enough to fill either side, which brings transmit drop-on-full and receive overflow within reach in a few dozen cycles. Switching the mode input during the run exercises the one-word capacity of single-buffer mode on the same instance.

// File: rtl/spi_fifo_pair.sv
module spi_fifo_pair #(
  parameter int DW    = 16,
  parameter int DEPTH = 16,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fifo_en,
  input  logic          tx_run,
  input  logic          rx_run,
  input  logic          tx_wr,
  input  logic [DW-1:0] tx_wdata,
  input  logic          core_idle,
  output logic          core_load,
  output logic [DW-1:0] core_tx_data,
  input  logic          core_rx_valid,
  input  logic [DW-1:0] core_rx_data,
  input  logic          rx_rd,
  output logic [DW-1:0] rx_rdata,
  output logic [CW-1:0] tx_count,
  output logic [CW-1:0] rx_count,
  input  logic [CW-1:0] tx_level,
  input  logic [CW-1:0] rx_level,
  input  logic          tx_ie,
  input  logic          rx_ie,
  input  logic          tx_flag_clr,
  input  logic          rx_flag_clr,
  input  logic          rx_ovf_clr,
  output logic          tx_flag,
  output logic          rx_flag,
  output logic          rx_ovf,
  output logic          tx_irq,
  output logic          rx_irq
);

  logic [DW-1:0] tx_mem [DEPTH];
  logic [DW-1:0] rx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp, rx_wp, rx_rp;

  wire [CW-1:0] cap    = fifo_en ? CW'(DEPTH) : CW'(1);
  wire          tx_push = tx_wr && tx_run && (tx_count < cap);
  wire          rx_room = rx_count < cap;
  wire          rx_push = core_rx_valid && rx_run && rx_room;
  wire          rx_pop  = rx_rd && rx_run && (rx_count != '0);
  wire          ovf_hit = core_rx_valid && rx_run && !rx_room;

  assign core_load    = core_idle && tx_run && (tx_count != '0);
  assign core_tx_data = tx_mem[tx_rp];
  assign rx_rdata     = rx_mem[rx_rp];
  assign tx_irq       = tx_flag && tx_ie;
  assign rx_irq       = rx_flag && rx_ie;

  always_ff @(posedge clk) begin
    if (tx_push) tx_mem[tx_wp] <= tx_wdata;
    if (rx_push) rx_mem[rx_wp] <= core_rx_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !tx_run) begin
      tx_wp <= '0; tx_rp <= '0; tx_count <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + 1'b1;
      if (core_load) tx_rp <= tx_rp + 1'b1;
      tx_count <= tx_count + CW'(tx_push) - CW'(core_load);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !rx_run) begin
      rx_wp <= '0; rx_rp <= '0; rx_count <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + 1'b1;
      if (rx_pop) rx_rp <= rx_rp + 1'b1;
      rx_count <= rx_count + CW'(rx_push) - CW'(rx_pop);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_flag <= 1'b0; rx_flag <= 1'b0; rx_ovf <= 1'b0;
    end else begin
      tx_flag <= tx_flag_clr ? 1'b0 : (tx_flag || (fifo_en && tx_count == tx_level));
      rx_flag <= rx_flag_clr ? 1'b0 : (rx_flag || (fifo_en && rx_count == rx_level));
      rx_ovf  <= rx_ovf_clr  ? 1'b0 : (rx_ovf || ovf_hit);
    end
  end

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= CW'(DEPTH) && rx_count <= CW'(DEPTH));
  p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_run && tx_wr && tx_count == CW'(DEPTH) && !core_load |=> tx_count == CW'(DEPTH));
  p_load_pops_r2: assert property (@(posedge clk) disable iff (!rst_n)
    core_load && !tx_wr |=> tx_count == $past(tx_count) - CW'(1));
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_run && core_rx_valid && rx_count == cap && !rx_rd && !rx_ovf_clr |=> rx_ovf && $stable(rx_count));
  p_ovf_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ovf && !rx_ovf_clr |=> rx_ovf);
  p_match_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_en && tx_count == tx_level && !tx_flag_clr |=> tx_flag);
  p_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_flag_clr || rx_flag_clr |=> !(tx_flag && $past(tx_flag_clr)) && !(rx_flag && $past(rx_flag_clr)));
  p_run_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_run || !rx_run |=> ($past(tx_run) || tx_count == '0) && ($past(rx_run) || rx_count == '0));

endmodule

// File: tb/test_spi_fifo_pair.sv
`timescale 1ns/1ps
module test_spi_fifo_pair;
  localparam int DW = 16, DEPTH = 16, CW = 5;

  logic clk = 0, rst_n = 0;
  logic fifo_en = 1, tx_run = 1, rx_run = 1;
  logic tx_wr = 0, core_idle = 0, core_rx_valid = 0, rx_rd = 0;
  logic [DW-1:0] tx_wdata = '0, core_rx_data = '0;
  logic [CW-1:0] tx_level = 5'd16, rx_level = 5'd3;
  logic tx_ie = 0, rx_ie = 0, tx_flag_clr = 0, rx_flag_clr = 0, rx_ovf_clr = 0;
  logic core_load, tx_flag, rx_flag, rx_ovf, tx_irq, rx_irq;
  logic [DW-1:0] core_tx_data, rx_rdata;
  logic [CW-1:0] tx_count, rx_count;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [DW-1:0] txq[$];
  logic [DW-1:0] rxq[$];

  always #2.5 clk = ~clk;

  spi_fifo_pair #(.DW(DW), .DEPTH(DEPTH)) i_spi_fifo_pair (
    .clk(clk), .rst_n(rst_n), .fifo_en(fifo_en), .tx_run(tx_run), .rx_run(rx_run),
    .tx_wr(tx_wr), .tx_wdata(tx_wdata), .core_idle(core_idle), .core_load(core_load),
    .core_tx_data(core_tx_data), .core_rx_valid(core_rx_valid), .core_rx_data(core_rx_data),
    .rx_rd(rx_rd), .rx_rdata(rx_rdata), .tx_count(tx_count), .rx_count(rx_count),
    .tx_level(tx_level), .rx_level(rx_level), .tx_ie(tx_ie), .rx_ie(rx_ie),
    .tx_flag_clr(tx_flag_clr), .rx_flag_clr(rx_flag_clr), .rx_ovf_clr(rx_ovf_clr),
    .tx_flag(tx_flag), .rx_flag(rx_flag), .rx_ovf(rx_ovf), .tx_irq(tx_irq), .rx_irq(rx_irq));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tx_push(input logic [DW-1:0] d, input bit keep);
    @(negedge clk); tx_wr = 1; tx_wdata = d;
    if (keep) txq.push_back(d);
    @(negedge clk); tx_wr = 0;
  endtask

  task automatic rx_send(input logic [DW-1:0] d, input bit keep);
    @(negedge clk); core_rx_valid = 1; core_rx_data = d;
    if (keep) rxq.push_back(d);
    @(negedge clk); core_rx_valid = 0;
  endtask

  task automatic rx_read();
    @(negedge clk);
    if (rxq.size() == 0) chk("R3 read with empty scoreboard", 1, 0);
    else chk("R3 rx order", int'(rx_rdata), int'(rxq.pop_front()));
    rx_rd = 1;
    @(negedge clk); rx_rd = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  // monitor: compares words handed to the shift engine (R2)
  always @(negedge clk) begin
    #1;
    if (rst_n && core_load) begin
      if (txq.size() == 0) chk("R2 unexpected core_load", 1, 0);
      else chk("R2 tx order", int'(core_tx_data), int'(txq.pop_front()));
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #500000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("reset tx_count", tx_count, 0);
    chk("reset rx_count", rx_count, 0);
    chk("reset flags", {tx_flag, rx_flag, rx_ovf, tx_irq, rx_irq, core_load}, 0);

    // R1: fill transmit side
    for (int i = 0; i < 16; i++) tx_push(16'h1000 + 16'(i), 1);
    chk("R1 tx full count 10000", tx_count, 16);
    tx_push(16'hDEAD, 0);
    chk("R1 tx write when full dropped", tx_count, 16);
    // R6: count 16 matched level 16
    chk("R6 tx flag on exact match", tx_flag, 1);
    // R8
    tx_ie = 1; @(negedge clk);
    chk("R8 tx_irq with enable", tx_irq, 1);
    tx_ie = 0; @(negedge clk);
    chk("R8 tx_irq masked", tx_irq, 0);
    // R7: clear while match persists
    @(negedge clk); tx_flag_clr = 1;
    @(negedge clk); tx_flag_clr = 0;
    chk("R7 tx flag cleared", tx_flag, 0);
    @(negedge clk);
    chk("R7 tx flag re-set on held match", tx_flag, 1);
    // R2: drain
    @(negedge clk); core_idle = 1;
    repeat (20) @(negedge clk);
    core_idle = 0;
    chk("R2 tx drained count", tx_count, 0);
    chk("R2 all words delivered", txq.size(), 0);

    // R3/R4: receive side
    for (int i = 0; i < 16; i++) rx_send(16'h2000 + 16'(i), 1);
    chk("R1 rx full count", rx_count, 16);
    chk("R6 rx flag after passing level 3", rx_flag, 1);
    rx_send(16'hBAD0, 0);
    chk("R4 overflow flag", rx_ovf, 1);
    chk("R4 count kept", rx_count, 16);
    for (int i = 0; i < 16; i++) rx_read();
    chk("R3 rx empty after reads", rx_count, 0);
    // R5
    repeat (3) @(negedge clk);
    chk("R5 ovf held while clear is 0", rx_ovf, 1);
    pulse(rx_ovf_clr);
    chk("R5 ovf cleared by 1", rx_ovf, 0);
    // R7: clear with no match
    pulse(rx_flag_clr);
    repeat (2) @(negedge clk);
    chk("R7 rx flag stays clear without match", rx_flag, 0);

    // R9: run bit
    for (int i = 0; i < 3; i++) tx_push(16'h3000 + 16'(i), 1);
    chk("R9 tx count before run low", tx_count, 3);
    @(negedge clk); tx_run = 0;
    @(negedge clk);
    chk("R9 count zero while run low", tx_count, 0);
    tx_push(16'h3333, 0);
    chk("R9 write ignored while run low", tx_count, 0);
    txq.delete();
    @(negedge clk); tx_run = 1;
    tx_push(16'hBEEF, 1);
    chk("R9 restart empty then one word", tx_count, 1);
    @(negedge clk); core_idle = 1;
    repeat (4) @(negedge clk);
    core_idle = 0;
    chk("R9 new word delivered", txq.size(), 0);

    // R10: single-buffer mode
    @(negedge clk); fifo_en = 0; tx_level = 5'd1;
    pulse(tx_flag_clr);
    rx_send(16'h4001, 1);
    rx_send(16'h4002, 0);
    chk("R10 rx holds one word", rx_count, 1);
    chk("R10 second word overflows", rx_ovf, 1);
    rx_read();
    pulse(rx_ovf_clr);
    tx_push(16'h5001, 1);
    tx_push(16'h5002, 0);
    chk("R10 tx holds one word", tx_count, 1);
    repeat (2) @(negedge clk);
    chk("R10 no level flag in buffer mode", tx_flag, 0);
    fifo_en = 1;
    repeat (2) @(negedge clk);
    chk("R6 flag after queue mode restored", tx_flag, 1);
    core_idle = 1;
    repeat (3) @(negedge clk);
    core_idle = 0;
    chk("R10 buffered word delivered", txq.size(), 0);

    done = 1;
    summary();
  end
endmodule